// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control core of a small 16-bit accumulator computer that shares one memory between program and data. It steps each instruction through a fixed series of phases: the word is fetched, decoded and, when it asks for it, passed through an extra pointer read. It is then executed. The block holds the program counter, address register, instruction register, data register and accumulator. It drives a synchronous, word-addressed memory with a one-cycle read latency. A simple character input port with a ready/acknowledge pair connects it to a peripheral.

Every instruction word has three fields. Bit 15 is the mode bit, bits 14..12 are the operation field and bits 11..0 are the address or sub-operation field. The operation field selects the class. Any value other than 7 is a memory-reference operation, and its second operand is always the accumulator. A value of 7 selects register control when bit 15 is 0, and input/output when bit 15 is 1. A few memory operations are supported, along with complement and clear of the accumulator and a single input-character operation. All other codes do nothing.

Top module: `acc_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pc_o` and `acc_o` are 0, and `mem_we` and `in_ack` are low. The block restarts by fetching from address 0.
- R2: Each instruction is read from the address held in `pc_o`. That counter increases by one (modulo 2^12) in the second cycle of every instruction. It therefore reads 1 two cycles after reset is released.
- R3: The class is decoded from bits 14..12 and bit 15. Values 0–6 are memory-reference. Value 7 with bit 15 = 0 is register control. Value 7 with bit 15 = 1 is input/output.
- R4: Operation 1 (add) sets the accumulator to accumulator + M[ea], modulo 2^16. A direct read operation takes 6 cycles.
- R5: Operation 0 sets the accumulator to accumulator AND M[ea]. Operation 2 loads M[ea] into the accumulator.
- R6: Operation 3 writes the accumulator to M[ea]. It asserts `mem_we` for exactly one cycle, with `mem_wdata` equal to the accumulator. An instruction fetched right after the store sees the new memory contents.
- R7: Operation 4 loads the program counter with ea, so the next instruction comes from ea.
- R8: For operations 0–6 with bit 15 = 1, ea is the low 12 bits of the word stored at the address field. This costs two extra cycles. With bit 15 = 0, ea is the address field itself.
- R9: Word 0x7200 inverts every accumulator bit. The change is visible 4 cycles after the instruction's fetch starts. Word 0x7800 clears the accumulator.
- R10: Word 0xF800 holds execution while `in_ready` is low. When `in_ready` is high in the execute cycle, `in_char` is written to accumulator bits 7..0, bits 15..8 are kept, and `in_ack` pulses high for one cycle.
- R11: Operations 5 and 6, register-control words other than 0x7200/0x7800, and input/output words other than 0xF800 change neither the accumulator nor memory. Control passes to the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (registered) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_wdata | output | 16 | Memory write data (registered) |
| mem_we | output | 1 | Memory write enable (registered) |
| in_char | input | 8 | Character offered by the input peripheral |
| in_ready | input | 1 | Peripheral has a character waiting |
| in_ack | output | 1 | One-cycle pulse when the character is taken |
| acc_o | output | 16 | Accumulator contents |
| pc_o | output | 12 | Program counter contents |

## Verification
Two events can meet in one cycle. The first is the peripheral's ready flag and the input instruction reaching its execute phase. The bench raises `in_ready` before reset is released, so the flag is already high when the instruction arrives. The acknowledge must then appear exactly 10 cycles after release, with the character merged into the accumulator, and it must not appear one cycle earlier. The second is a store that rewrites the very next instruction word. The memory write lands on the edge just before that word's fetch read. The bench judges this by whether the rewritten instruction, not the original one, is the one executed.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  // Phases of one instruction
  typedef enum logic [3:0] {
    ST_FA,   // present program counter as address
    ST_FW,   // memory read in flight, counter steps
    ST_DEC,  // capture instruction word
    ST_IW,   // pointer read in flight
    ST_IL,   // capture pointer as effective address
    ST_EX,   // execute / launch operand read
    ST_RD,   // capture operand into data register
    ST_OP,   // combine operand with accumulator
    ST_WR    // store cycle
  } seq_t;

  typedef enum logic [3:0] {
    K_NOP, K_AND, K_ADD, K_LDA, K_STA, K_JMP, K_CMA, K_CLA, K_INP
  } kind_t;

  localparam logic [2:0]  OPC_AND = 3'd0;
  localparam logic [2:0]  OPC_ADD = 3'd1;
  localparam logic [2:0]  OPC_LDA = 3'd2;
  localparam logic [2:0]  OPC_STA = 3'd3;
  localparam logic [2:0]  OPC_JMP = 3'd4;
  localparam logic [2:0]  OPC_EXT = 3'd7;

  localparam logic [11:0] RC_INVERT = 12'h200;
  localparam logic [11:0] RC_ZERO   = 12'h800;
  localparam logic [11:0] IOC_READ  = 12'h800;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [WORD_W-1:0] word,
  output kind_t             kind,
  output logic              indirect
);
  localparam int OPC_HI = WORD_W - 2;
  localparam int OPC_LO = WORD_W - 4;

  logic              mode;
  logic [2:0]        opc;
  logic [ADDR_W-1:0] fld;

  assign mode = word[WORD_W-1];
  assign opc  = word[OPC_HI:OPC_LO];
  assign fld  = word[ADDR_W-1:0];

  always_comb begin
    kind = K_NOP;
    if (opc != OPC_EXT) begin
      unique case (opc)
        OPC_AND: kind = K_AND;
        OPC_ADD: kind = K_ADD;
        OPC_LDA: kind = K_LDA;
        OPC_STA: kind = K_STA;
        OPC_JMP: kind = K_JMP;
        default: kind = K_NOP;
      endcase
    end else if (!mode) begin
      if (fld == RC_INVERT)    kind = K_CMA;
      else if (fld == RC_ZERO) kind = K_CLA;
    end else if (fld == IOC_READ) begin
      kind = K_INP;
    end
  end

  assign indirect = mode && (opc != OPC_EXT);

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CHAR_W = 8
) (
  input  kind_t             kind,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] opnd,
  input  logic [CHAR_W-1:0] chr,
  output logic [WORD_W-1:0] res
);
  always_comb begin
    unique case (kind)
      K_AND:   res = acc & opnd;
      K_ADD:   res = acc + opnd;
      K_LDA:   res = opnd;
      K_CMA:   res = ~acc;
      K_CLA:   res = '0;
      K_INP:   res = {acc[WORD_W-1:CHAR_W], chr};
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_ready,
  output logic              in_ack,
  output logic [WORD_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  seq_t              st_q;
  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [WORD_W-1:0] ir_q, dr_q, acc_q, wd_q;
  logic              we_q, ack_q;

  logic [WORD_W-1:0] dec_word;
  kind_t             kind;
  logic              ind;
  logic [WORD_W-1:0] alu_res;

  // During the capture cycle decode straight from the read bus
  assign dec_word = (st_q == ST_DEC) ? mem_rdata : ir_q;

  acc_seq_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
    .word     (dec_word),
    .kind     (kind),
    .indirect (ind)
  );

  acc_seq_alu #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_alu (
    .kind (kind),
    .acc  (acc_q),
    .opnd (dr_q),
    .chr  (in_char),
    .res  (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_FA;
      pc_q  <= '0;
      ar_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      acc_q <= '0;
      wd_q  <= '0;
      we_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      ack_q <= 1'b0;
      unique case (st_q)
        ST_FA: begin
          ar_q <= pc_q;
          st_q <= ST_FW;
        end
        ST_FW: begin
          pc_q <= pc_q + PC_STEP;
          st_q <= ST_DEC;
        end
        ST_DEC: begin
          ir_q <= mem_rdata;
          ar_q <= mem_rdata[ADDR_W-1:0];
          st_q <= ind ? ST_IW : ST_EX;
        end
        ST_IW: st_q <= ST_IL;
        ST_IL: begin
          ar_q <= mem_rdata[ADDR_W-1:0];
          st_q <= ST_EX;
        end
        ST_EX: begin
          unique case (kind)
            K_AND, K_ADD, K_LDA: st_q <= ST_RD;
            K_STA: begin
              we_q <= 1'b1;
              wd_q <= acc_q;
              st_q <= ST_WR;
            end
            K_JMP: begin
              pc_q <= ar_q;
              st_q <= ST_FA;
            end
            K_CMA, K_CLA: begin
              acc_q <= alu_res;
              st_q  <= ST_FA;
            end
            K_INP: begin
              if (in_ready) begin
                acc_q <= alu_res;
                ack_q <= 1'b1;
                st_q  <= ST_FA;
              end
            end
            default: st_q <= ST_FA;
          endcase
        end
        ST_RD: begin
          dr_q <= mem_rdata;
          st_q <= ST_OP;
        end
        ST_OP: begin
          acc_q <= alu_res;
          st_q  <= ST_FA;
        end
        ST_WR: st_q <= ST_FA;
        default: st_q <= ST_FA;
      endcase
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = wd_q;
  assign mem_we    = we_q;
  assign in_ack    = ack_q;
  assign acc_o     = acc_q;
  assign pc_o      = pc_q;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
  import acc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input seq_t              st,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] wdata,
  input logic              we,
  input logic              ack,
  input logic              in_ready
);
  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0 && acc == '0 && !we && !ack));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FW) |=> (pc == $past(pc) + 1'b1));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (st != ST_FW && st != ST_EX) |=> $stable(pc));

  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);

  assert_we_data_R6: assert property (@(posedge clk) disable iff (rst)
    we |-> (wdata == acc));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_ack_ready_R10: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(in_ready));

  assert_acc_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FA || st == ST_FW || st == ST_DEC || st == ST_IW ||
     st == ST_IL || st == ST_RD || st == ST_WR) |=> $stable(acc));
endmodule

bind acc_sequencer acc_seq_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .st       (st_q),
  .pc       (pc_q),
  .acc      (acc_q),
  .wdata    (wd_q),
  .we       (we_q),
  .ack      (ack_q),
  .in_ready (in_ready)
);

// File: tb/sim_acc_sequencer.sv
module sim_acc_sequencer;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  // {op[51:49], indirect[48], acc_init[47:32], operand[31:16], expected[15:0]}
  localparam logic [51:0] VEC [NVEC] = '{
    {3'd1, 1'b0, 16'h1234, 16'h0F0F, 16'h2143},
    {3'd1, 1'b0, 16'hFFFF, 16'h0002, 16'h0001},
    {3'd0, 1'b0, 16'hF0F0, 16'h3C3C, 16'h3030},
    {3'd2, 1'b0, 16'h1111, 16'hBEEF, 16'hBEEF},
    {3'd1, 1'b1, 16'h0100, 16'h0023, 16'h0123},
    {3'd5, 1'b0, 16'h5555, 16'h9999, 16'h5555},
    {3'd0, 1'b1, 16'hFFFF, 16'h0F0F, 16'h0F0F}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [7:0]  in_char = 8'h00;
  logic        in_ready = 1'b0;
  logic        in_ack;
  logic [15:0] acc_o;
  logic [11:0] pc_o;

  logic [15:0] ram [256];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_a = 8'h00;
  logic [15:0] tb_d = 16'h0000;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_we)     ram[mem_addr[7:0]] <= mem_wdata;
    else if (tb_we) ram[tb_a] <= tb_d;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  acc_sequencer u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .in_char(in_char),
    .in_ready(in_ready), .in_ack(in_ack), .acc_o(acc_o), .pc_o(pc_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_a = a; tb_d = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic start;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic hold_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int wes;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 pc", {4'h0, pc_o}, 16'h0000);
    chk("R1 acc", acc_o, 16'h0000);
    chk("R1 we/ack", {14'h0, mem_we, in_ack}, 16'h0000);

    // Table walk: R3 class decode with R4/R5/R8/R11 operations
    for (int i = 0; i < NVEC; i++) begin
      logic [51:0] v;
      v = VEC[i];
      hold_reset();
      poke(8'h00, 16'h2080);
      poke(8'h01, {v[48], v[51:49], 12'h081});
      poke(8'h02, 16'h3082);
      poke(8'h03, 16'h4003);
      poke(8'h80, v[47:32]);
      if (v[48]) begin
        poke(8'h81, 16'h0090);
        poke(8'h90, v[31:16]);
      end else begin
        poke(8'h81, v[31:16]);
      end
      poke(8'h82, 16'h0000);
      start();
      repeat (40) @(negedge clk);
      chk(v[48] ? "R8 stored" : (v[51:49] == 3'd5 ? "R11 stored" :
          (v[51:49] == 3'd1 ? "R4 stored" : "R5 stored")), ram[8'h82], v[15:0]);
      chk("R3 acc", acc_o, v[15:0]);
    end

    // R2/R9/R7/R11: timing, complement, no-op codes, jump over clear
    hold_reset();
    poke(8'h00, 16'h2080); poke(8'h01, 16'h7200); poke(8'h02, 16'h7001);
    poke(8'h03, 16'hF001); poke(8'h04, 16'h5000); poke(8'h05, 16'h4007);
    poke(8'h06, 16'h7800); poke(8'h07, 16'h3082); poke(8'h08, 16'h4008);
    poke(8'h80, 16'h00FF); poke(8'h82, 16'h0000);
    start();
    repeat (2) @(negedge clk);
    chk("R2 pc after first fetch", {4'h0, pc_o}, 16'h0001);
    repeat (6) @(negedge clk);
    chk("R2 pc second fetch", {4'h0, pc_o}, 16'h0002);
    repeat (1) @(negedge clk);
    chk("R9 acc before invert", acc_o, 16'h00FF);
    repeat (1) @(negedge clk);
    chk("R9 acc inverted", acc_o, 16'hFF00);
    repeat (50) @(negedge clk);
    chk("R11 stored after no-ops", ram[8'h82], 16'hFF00);
    chk("R7 clear skipped by jump", acc_o, 16'hFF00);
    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 acc after reset", acc_o, 16'h0000);
    chk("R1 pc after reset", {4'h0, pc_o}, 16'h0000);

    // R10: stall then take a character; R9 clear
    poke(8'h00, 16'h2080); poke(8'h01, 16'hF800); poke(8'h02, 16'h3082);
    poke(8'h03, 16'h7800); poke(8'h04, 16'h4004);
    poke(8'h80, 16'hAB00); poke(8'h82, 16'h0000);
    start();
    wes = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (in_ack) wes++;
    end
    chk("R10 no ack while not ready", 16'(wes), 16'h0000);
    chk("R10 pc held during stall", {4'h0, pc_o}, 16'h0002);
    chk("R10 acc held during stall", acc_o, 16'hAB00);
    in_char = 8'h5C; in_ready = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (in_ack) break;
    end
    chk("R10 ack seen", {15'h0, in_ack}, 16'h0001);
    chk("R10 char merged", acc_o, 16'hAB5C);
    in_ready = 1'b0;
    @(negedge clk);
    chk("R10 ack one cycle", {15'h0, in_ack}, 16'h0000);
    repeat (20) @(negedge clk);
    chk("R10 stored char", ram[8'h82], 16'hAB5C);
    chk("R9 cleared", acc_o, 16'h0000);

    // R10 corner: ready already high when execute is reached
    hold_reset();
    in_char = 8'h3E; in_ready = 1'b1;
    start();
    repeat (9) @(negedge clk);
    chk("R10 no early ack", {15'h0, in_ack}, 16'h0000);
    @(negedge clk);
    chk("R10 immediate ack", {15'h0, in_ack}, 16'h0001);
    chk("R10 immediate char", acc_o, 16'hAB3E);
    in_ready = 1'b0;

    // R6: store rewrites the next instruction
    hold_reset();
    poke(8'h00, 16'h2080); poke(8'h01, 16'h3002); poke(8'h02, 16'h5000);
    poke(8'h03, 16'h3082); poke(8'h04, 16'h4004);
    poke(8'h80, 16'h7200); poke(8'h82, 16'h0000);
    start();
    wes = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (mem_we) wes++;
    end
    chk("R6 write cycles", 16'(wes), 16'h0002);
    chk("R6 rewritten word", ram[8'h02], 16'h7200);
    chk("R6 rewritten word executed", ram[8'h82], 16'h8DFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule